// File: doc/BRIEF.md
# Processor Status Flags Register

This block holds the eight status bits of a processor core and decides, once per clock, how each bit changes. The execute stage sends it masked condition-code results (carry, zero, sign, overflow), an operand to be tested for zero, masked writes of the whole flags byte, set/clear strobes for two software-owned bits, and a strobe that marks entry into an interrupt or system exception. The block presents the registered flags byte, a five-bit view of the flags that conditional branches use, and the combinational result of the zero test on the widened operand.

The "blank" bit records whether the tested operand was zero before the operation. A short memory operand is first widened to the full data width by zero or sign extension, as the operation selects. The "chain enable" bit takes the previous master interrupt enable when an interrupt is entered, so interrupt chaining stays off if interrupts were globally off at that moment. The master enable is cleared at the same edge. In the entry cycle the flags output still shows the word from before entry, and the stack logic pushes that word.

Top module: `cpu_status_flags`

## Requirements
- R1: While `rst_n` is low, every flag is 0 on the next edge, including the user bit, chain enable and master enable.
- R2: The flags byte has this fixed layout: bit 7 carry, bit 6 zero, bit 5 sign, bit 4 overflow, bit 3 blank, bit 2 user, bit 1 chain enable, bit 0 master enable. `cond_flags_o` is {carry, zero, sign, overflow, blank}. The user bit and the enables are not part of it.
- R3: `alu_mask` bits 3..0 select carry, zero, sign and overflow. Each selected flag takes the matching `alu_flags` bit at the next edge. Unselected flags keep their values.
- R4: When `blank_req` is high, the blank flag takes the value of `blank_zero_o` at the next edge: 1 if the widened operand is zero, else 0.
- R5: `op_size` 0 widens bits 7..0, 1 widens bits 15..0, and 2 or 3 takes the whole operand. `op_signed`=1 selects sign extension and 0 selects zero extension. `wide_o` shows the widened value combinationally.
- R6: When `wr_en` is high, each flag whose `wr_mask` bit is set takes the `wr_data` bit at the same position. For that flag this overrides the condition-code and blank updates.
- R7: The user bit changes only through `user_set`, `user_clr` or a masked write. The strobes override a write, and clear wins over set. Condition-code updates never change the user bit.
- R8: The chain enable changes only through `chain_set`, `chain_clr`, a masked write or interrupt entry. Clear wins over set.
- R9: On `irq_entry`, the chain enable takes the previous master enable and the master enable goes to 0 at the next edge. This overrides writes and strobes to those two bits. `flags_o` during the entry cycle is the pre-entry word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_mask | input | 4 | Condition-code update select {C,Z,S,V} |
| alu_flags | input | 4 | New condition-code values {C,Z,S,V} |
| blank_req | input | 1 | Load the blank flag from the zero test |
| test_operand | input | DATA_W | Operand to be tested for zero |
| op_size | input | 2 | Operand width: 0 byte, 1 half, 2/3 full |
| op_signed | input | 1 | 1 sign-extend, 0 zero-extend |
| wr_en | input | 1 | Masked flags write (pop or explicit load) |
| wr_mask | input | 8 | Per-bit write select |
| wr_data | input | 8 | Flags value to write |
| user_set | input | 1 | Set user bit |
| user_clr | input | 1 | Clear user bit |
| chain_set | input | 1 | Set chain enable |
| chain_clr | input | 1 | Clear chain enable |
| irq_entry | input | 1 | Interrupt or exception entry strobe |
| flags_o | output | 8 | Registered flags byte |
| cond_flags_o | output | 5 | {C,Z,S,V,B} for branch evaluation |
| wide_o | output | DATA_W | Widened test operand |
| blank_zero_o | output | 1 | Widened operand is zero |

## Verification
`wide_o` and `blank_zero_o` are combinational, so the bench reads them in the same cycle, one time step after it drives the inputs. Every flag update (R1, R3, R4, R6, R7, R8, R9) shows up on `flags_o` one edge after the request. The bench drives inputs on the falling edge and compares on the next falling edge, which is the first sample point after the single register. The R9 check of the pushed word is taken during the entry cycle itself, before the edge that changes the enables.

// File: rtl/flags_pkg.sv
package flags_pkg;
  localparam int FLAG_W  = 8;
  localparam int COND_W  = 5;
  localparam int ALU_W   = 4;
  localparam int BIT_C   = 7;
  localparam int BIT_Z   = 6;
  localparam int BIT_S   = 5;
  localparam int BIT_V   = 4;
  localparam int BIT_B   = 3;
  localparam int BIT_U   = 2;
  localparam int BIT_CE  = 1;
  localparam int BIT_IE  = 0;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_FULL  = 2'd2,
    SZ_FULL2 = 2'd3
  } opsize_e;

  // set/clear strobe resolution: clear dominates, else keep
  function automatic logic strobe_bit(input logic cur, input logic s, input logic c);
    if (c)      return 1'b0;
    else if (s) return 1'b1;
    else        return cur;
  endfunction
endpackage

// File: rtl/flags_widen.sv
module flags_widen
  import flags_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [DATA_W-1:0] wide,
  output logic              is_zero
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  function automatic logic [DATA_W-1:0] widen_op(
    input logic [DATA_W-1:0] v, input logic [1:0] sz, input logic s);
    logic [DATA_W-1:0] r;
    logic ext;
    r = v;
    unique case (opsize_e'(sz))
      SZ_BYTE: begin
        ext = s & v[BYTE_W-1];
        r   = {{(DATA_W-BYTE_W){ext}}, v[BYTE_W-1:0]};
      end
      SZ_HALF: begin
        ext = s & v[HALF_W-1];
        r   = {{(DATA_W-HALF_W){ext}}, v[HALF_W-1:0]};
      end
      default: r = v;
    endcase
    return r;
  endfunction

  always_comb begin
    wide    = widen_op(src, size, sgn);
    is_zero = (wide == '0);
  end
endmodule

// File: rtl/flags_next.sv
module flags_next
  import flags_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  logic [ALU_W-1:0]  alu_mask,
  input  logic [ALU_W-1:0]  alu_flags,
  input  logic              blank_req,
  input  logic              blank_hit,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_mask,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic              user_set,
  input  logic              user_clr,
  input  logic              chain_set,
  input  logic              chain_clr,
  input  logic              irq_entry,
  output logic [FLAG_W-1:0] nxt
);
  logic [FLAG_W-1:0] exec_val;
  logic [FLAG_W-1:0] wr_val;

  // stage 1: execute-stage updates on the condition codes and blank
  always_comb begin
    exec_val = cur;
    for (int i = 0; i < ALU_W; i++) begin
      if (alu_mask[i]) exec_val[BIT_V + i] = alu_flags[i];
    end
    if (blank_req) exec_val[BIT_B] = blank_hit;
  end

  // stage 2: masked whole-word write overrides execute updates
  generate
    for (genvar g = 0; g < FLAG_W; g++) begin : g_wr
      assign wr_val[g] = (wr_en && wr_mask[g]) ? wr_data[g] : exec_val[g];
    end
  endgenerate

  // stage 3: strobes, then interrupt entry on the enables
  always_comb begin
    nxt         = wr_val;
    nxt[BIT_U]  = strobe_bit(wr_val[BIT_U],  user_set,  user_clr);
    nxt[BIT_CE] = strobe_bit(wr_val[BIT_CE], chain_set, chain_clr);
    if (irq_entry) begin
      nxt[BIT_CE] = cur[BIT_IE];
      nxt[BIT_IE] = 1'b0;
    end
  end
endmodule

// File: rtl/cpu_status_flags.sv
module cpu_status_flags
  import flags_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        alu_mask,
  input  logic [3:0]        alu_flags,
  input  logic              blank_req,
  input  logic [DATA_W-1:0] test_operand,
  input  logic [1:0]        op_size,
  input  logic              op_signed,
  input  logic              wr_en,
  input  logic [7:0]        wr_mask,
  input  logic [7:0]        wr_data,
  input  logic              user_set,
  input  logic              user_clr,
  input  logic              chain_set,
  input  logic              chain_clr,
  input  logic              irq_entry,
  output logic [7:0]        flags_o,
  output logic [4:0]        cond_flags_o,
  output logic [DATA_W-1:0] wide_o,
  output logic              blank_zero_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;
  logic              blank_hit;

  flags_widen #(.DATA_W(DATA_W)) u_widen (
    .src     (test_operand),
    .size    (op_size),
    .sgn     (op_signed),
    .wide    (wide_o),
    .is_zero (blank_hit)
  );

  flags_next u_next (
    .cur       (flags_q),
    .alu_mask  (alu_mask),
    .alu_flags (alu_flags),
    .blank_req (blank_req),
    .blank_hit (blank_hit),
    .wr_en     (wr_en),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data),
    .user_set  (user_set),
    .user_clr  (user_clr),
    .chain_set (chain_set),
    .chain_clr (chain_clr),
    .irq_entry (irq_entry),
    .nxt       (flags_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o      = flags_q;
  assign cond_flags_o = flags_q[BIT_C:BIT_B];
  assign blank_zero_o = blank_hit;
endmodule

// File: rtl/flags_checker.sv
module flags_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] alu_mask,
  input logic       blank_req,
  input logic       blank_hit,
  input logic       wr_en,
  input logic [7:0] wr_mask,
  input logic       user_set,
  input logic       user_clr,
  input logic       chain_set,
  input logic       chain_clr,
  input logic       irq_entry,
  input logic [7:0] flags_o
);
  a_r9_chain_takes_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> flags_o[1] == $past(flags_o[0]));

  a_r9_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> !flags_o[0]);

  a_r7_user_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_set && !user_clr && !(wr_en && wr_mask[2])) |=> $stable(flags_o[2]));

  a_r8_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_set && !chain_clr && !irq_entry && !(wr_en && wr_mask[1]))
      |=> $stable(flags_o[1]));

  a_r4_blank_load: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_req && !(wr_en && wr_mask[3])) |=> flags_o[3] == $past(blank_hit));

  a_r3_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_mask[3] && !(wr_en && wr_mask[7])) |=> $stable(flags_o[7]));
endmodule

bind cpu_status_flags flags_checker u_flags_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alu_mask  (alu_mask),
  .blank_req (blank_req),
  .blank_hit (blank_hit),
  .wr_en     (wr_en),
  .wr_mask   (wr_mask),
  .user_set  (user_set),
  .user_clr  (user_clr),
  .chain_set (chain_set),
  .chain_clr (chain_clr),
  .irq_entry (irq_entry),
  .flags_o   (flags_o)
);

// File: tb/test_cpu_status_flags.sv
module test_cpu_status_flags;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    alu_mask, alu_flags;
  logic          blank_req;
  logic [DW-1:0] test_operand;
  logic [1:0]    op_size;
  logic          op_signed;
  logic          wr_en;
  logic [7:0]    wr_mask, wr_data;
  logic          user_set, user_clr, chain_set, chain_clr, irq_entry;
  logic [7:0]    flags_o;
  logic [4:0]    cond_flags_o;
  logic [DW-1:0] wide_o;
  logic          blank_zero_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model = '0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_status_flags #(.DATA_W(DW)) i_cpu_status_flags (.*);

  function automatic logic [DW-1:0] ref_widen(logic [DW-1:0] v, logic [1:0] sz, logic s);
    longint sv;
    if (sz == 2'd0) begin
      sv = s ? longint'($signed(v[7:0])) : longint'(v[7:0]);
      return sv[DW-1:0];
    end
    if (sz == 2'd1) begin
      sv = s ? longint'($signed(v[15:0])) : longint'(v[15:0]);
      return sv[DW-1:0];
    end
    return v;
  endfunction

  // behavioural reference, one update per rising edge
  always @(posedge clk) begin
    logic [7:0] n;
    if (!rst_n) model <= 8'h00;
    else begin
      n = model;
      if (alu_mask[3]) n[7] = alu_flags[3];
      if (alu_mask[2]) n[6] = alu_flags[2];
      if (alu_mask[1]) n[5] = alu_flags[1];
      if (alu_mask[0]) n[4] = alu_flags[0];
      if (blank_req) n[3] = (ref_widen(test_operand, op_size, op_signed) == 0);
      if (wr_en) n = (n & ~wr_mask) | (wr_data & wr_mask);
      if (user_clr) n[2] = 1'b0; else if (user_set) n[2] = 1'b1;
      if (chain_clr) n[1] = 1'b0; else if (chain_set) n[1] = 1'b1;
      if (irq_entry) begin n[1] = model[0]; n[0] = 1'b0; end
      model <= n;
    end
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_mask = '0; alu_flags = '0; blank_req = 0; test_operand = '0;
    op_size = 2'd2; op_signed = 0; wr_en = 0; wr_mask = '0; wr_data = '0;
    user_set = 0; user_clr = 0; chain_set = 0; chain_clr = 0; irq_entry = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    step(); step();
    chk("R1 reset", flags_o, 8'h00);
    rst_n = 1;

    // R6 full write
    wr_en = 1; wr_mask = 8'hFF; wr_data = 8'hAD; step(); idle();
    chk("R6 write", flags_o, 8'hAD);
    chk("R2 cond view", cond_flags_o, 5'b10101);

    // R3 masked condition codes: zero and overflow only
    alu_mask = 4'b0101; alu_flags = 4'b1111; step(); idle();
    chk("R3 masked alu", flags_o, 8'hFD);

    // R5/R4 half-word nonzero
    blank_req = 1; test_operand = 32'h0000_0100; op_size = 2'd1; #1;
    chk("R5 half widen", wide_o, 32'h0000_0100);
    chk("R4 zero test", blank_zero_o, 1'b0);
    step(); idle();
    chk("R4 blank cleared", flags_o, 8'hF5);

    // R4 byte of a nonzero word is zero
    blank_req = 1; test_operand = 32'h1234_5600; op_size = 2'd0; step(); idle();
    chk("R4 blank set", flags_o, 8'hFD);

    // R5 sign versus zero extension
    test_operand = 32'h0000_0080; op_size = 2'd0; op_signed = 1; #1;
    chk("R5 sign byte", wide_o, 32'hFFFF_FF80);
    op_signed = 0; #1;
    chk("R5 zero byte", wide_o, 32'h0000_0080);
    test_operand = 32'h0001_8000; op_size = 2'd1; op_signed = 1; #1;
    chk("R5 sign half", wide_o, 32'hFFFF_8000);
    step(); idle();

    // R6 write overrides blank on same bit
    blank_req = 1; test_operand = 32'h0; wr_en = 1; wr_mask = 8'h08; wr_data = 8'h00;
    step(); idle();
    chk("R6 write over blank", flags_o, 8'hF5);

    // R7 user bit
    user_clr = 1; step(); idle();
    chk("R7 user clear", flags_o, 8'hF1);
    user_set = 1; wr_en = 1; wr_mask = 8'h04; wr_data = 8'h00; step(); idle();
    chk("R7 set over write", flags_o, 8'hF5);
    user_set = 1; user_clr = 1; step(); idle();
    chk("R7 clear wins", flags_o, 8'hF1);
    alu_mask = 4'hF; alu_flags = 4'h0; step(); idle();
    chk("R7 alu no effect", flags_o, 8'h01);

    // R8 chain enable
    chain_set = 1; step(); idle();
    chk("R8 chain set", flags_o, 8'h03);
    chain_clr = 1; chain_set = 1; step(); idle();
    chk("R8 chain clear wins", flags_o, 8'h01);

    // R9 interrupt entry with a conflicting write
    irq_entry = 1; wr_en = 1; wr_mask = 8'h03; wr_data = 8'h03; #1;
    chk("R9 pushed word", flags_o, 8'h01);
    step(); idle();
    chk("R9 entry", flags_o, 8'h02);
    irq_entry = 1; chain_set = 1; step(); idle();
    chk("R9 entry ie=0", flags_o, 8'h00);

    // random phase against the model
    for (int k = 0; k < 3000; k++) begin
      alu_mask = 4'($urandom); alu_flags = 4'($urandom);
      blank_req = ($urandom % 3) == 0;
      test_operand = ($urandom % 2) ? 32'($urandom) : 32'($urandom % 4) << (($urandom % 4) * 8);
      op_size = 2'($urandom); op_signed = 1'($urandom);
      wr_en = ($urandom % 4) == 0; wr_mask = 8'($urandom); wr_data = 8'($urandom);
      user_set = ($urandom % 6) == 0; user_clr = ($urandom % 6) == 0;
      chain_set = ($urandom % 6) == 0; chain_clr = ($urandom % 6) == 0;
      irq_entry = ($urandom % 8) == 0;
      rst_n = ($urandom % 200) != 0;
      #1;
      chk("R5 random widen", wide_o, ref_widen(test_operand, op_size, op_signed));
      chk("R4 random zero", blank_zero_o, ref_widen(test_operand, op_size, op_signed) == 0);
      step();
      chk("R3,R6,R7,R8,R9,R1 random flags", flags_o, model);
      chk("R2 random cond", cond_flags_o, model[7:3]);
    end
    rst_n = 1;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule